// File: doc/BRIEF.md
# Interleaved Stream Correlated Differencer

This block sits behind an external ADC that digitizes the output of an 8-to-1 analog multiplexer. The ADC delivers one interleaved word stream. Successive words belong to successive channels, and the stream runs eight times faster than any single channel: each channel is sampled every 500 ns, which gives a 16 MHz word rate. The block assigns each accepted word to a channel slot. It keeps the last sample of every channel and produces the dual correlated sample for that channel, which is the current reading minus the same channel's previous reading. It does this continuously, so no acquisition dead time is added.

A frame marker travelling with a word realigns the slot counter to channel 0. The first word a channel receives after reset has nothing to be compared with, so it only loads that channel's history. Every later word of that channel yields a signed difference one clock after it is accepted. The difference is tagged with the channel index.

Top module: `mxd_stream_dcs`

## Requirements
- R1: When reset is released, `out_valid` is 0, `out_chan` is 0 and `out_diff` is 0.
- R2: Each word accepted with `in_valid`=1 and `in_frame`=0 goes to the slot that follows the previous word's slot, and slot 7 is followed by slot 0. The first word after reset goes to slot 0. One cycle after a word is accepted, `out_chan` shows that word's slot, whether or not `out_valid` is set.
- R3: A word accepted with `in_frame`=1 goes to slot 0, and the next plain word goes to slot 1.
- R4: `in_frame` has no effect while `in_valid` is 0. The slot sequence continues as if the marker had not been present.
- R5: The first word of each channel after reset gives `out_valid`=0 one cycle later.
- R6: Every later word of a channel gives `out_valid`=1 exactly one cycle after it is accepted. In that cycle `out_diff` equals the current sample minus that channel's previous sample.
- R7: `out_diff` is 11-bit two's complement. A rise from 0 to 1023 reads +1023 (0x3FF), and a fall from 1023 to 0 reads -1023 (0x401).
- R8: A cycle with `in_valid`=0 gives `out_valid`=0 in the following cycle. Such cycles change neither the channel histories nor the slot sequence.
- R9: Reset clears every channel's history. After a new reset, the first word of each channel again gives no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_frame | input | 1 | Frame marker; forces slot 0 for a valid word |
| in_sample | input | 10 | Unsigned ADC sample |
| out_valid | output | 1 | Difference strobe |
| out_chan | output | 3 | Slot of the most recently accepted word |
| out_diff | output | 11 | Signed current-minus-previous difference |

## Verification
If the slot counter is wrong, `out_chan` shows it one cycle after the faulty word. Every difference after that point is then taken against another channel's history, so the values go wrong from the next pass onward. If a history entry is wrong, the fault only shows on that channel's next word, which can be up to eight accepted words later. A seen flag that is not cleared shows as a spurious `out_valid` on the first pass after reset. The directed scenarios place known values on each channel so that each of these faults produces an exact mismatch.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
  localparam int unsigned MXD_CHANNELS_DEF = 8;
  localparam int unsigned MXD_SAMPLE_W_DEF = 10;

  function automatic int unsigned mxd_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mxd_slot_counter.sv
module mxd_slot_counter #(
  parameter int unsigned CHANNELS = 8,
  localparam int unsigned CH_W = mxd_pkg::mxd_idx_w(CHANNELS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            word_ok,
  input  logic            frame_mark,
  output logic [CH_W-1:0] slot_now
);
  localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(CHANNELS - 1);

  logic [CH_W-1:0] next_slot;

  // a frame marker only matters together with an accepted word
  always_comb begin
    slot_now = (word_ok && frame_mark) ? '0 : next_slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_slot <= '0;
    end else if (word_ok) begin
      next_slot <= (slot_now == LAST_SLOT) ? '0 : slot_now + 1'b1;
    end
  end
endmodule

// File: rtl/mxd_history.sv
module mxd_history #(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned SAMPLE_W = 10,
  localparam int unsigned CH_W = mxd_pkg::mxd_idx_w(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     idx,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic [SAMPLE_W-1:0] prev_data,
  output logic                prev_seen
);
  // distributed-RAM style: sync write, async read, no reset on data
  logic [SAMPLE_W-1:0] mem [CHANNELS];
  logic [CHANNELS-1:0] seen;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wr_data;
    end
  end

  assign prev_data = mem[idx];
  assign prev_seen = seen[idx];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_seen
    always_ff @(posedge clk) begin
      if (rst) begin
        seen[g] <= 1'b0;
      end else if (wr_en && (idx == CH_W'(g))) begin
        seen[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mxd_diff_stage.sv
module mxd_diff_stage #(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned SAMPLE_W = 10,
  localparam int unsigned CH_W   = mxd_pkg::mxd_idx_w(CHANNELS),
  localparam int unsigned DIFF_W = SAMPLE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ok,
  input  logic              have_prev,
  input  logic [CH_W-1:0]   slot,
  input  logic [SAMPLE_W-1:0] cur,
  input  logic [SAMPLE_W-1:0] prev,
  output logic              q_valid,
  output logic [CH_W-1:0]   q_chan,
  output logic [DIFF_W-1:0] q_diff
);
  logic [DIFF_W-1:0] delta;

  always_comb begin
    delta = {1'b0, cur} - {1'b0, prev};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_chan  <= '0;
      q_diff  <= '0;
    end else begin
      q_valid <= word_ok && have_prev;
      if (word_ok) begin
        q_chan <= slot;
      end
      if (word_ok && have_prev) begin
        q_diff <= delta;
      end
    end
  end
endmodule

// File: rtl/mxd_stream_dcs.sv
module mxd_stream_dcs #(
  parameter int unsigned CHANNELS = mxd_pkg::MXD_CHANNELS_DEF,
  parameter int unsigned SAMPLE_W = mxd_pkg::MXD_SAMPLE_W_DEF,
  localparam int unsigned CH_W   = mxd_pkg::mxd_idx_w(CHANNELS),
  localparam int unsigned DIFF_W = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_frame,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [DIFF_W-1:0]   out_diff
);
  logic [CH_W-1:0]     slot;
  logic [SAMPLE_W-1:0] prev;
  logic                seen_prev;

  mxd_slot_counter #(.CHANNELS(CHANNELS)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .word_ok    (in_valid),
    .frame_mark (in_frame),
    .slot_now   (slot)
  );

  mxd_history #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (in_valid),
    .idx       (slot),
    .wr_data   (in_sample),
    .prev_data (prev),
    .prev_seen (seen_prev)
  );

  mxd_diff_stage #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_diff (
    .clk       (clk),
    .rst       (rst),
    .word_ok   (in_valid),
    .have_prev (seen_prev),
    .slot      (slot),
    .cur       (in_sample),
    .prev      (prev),
    .q_valid   (out_valid),
    .q_chan    (out_chan),
    .q_diff    (out_diff)
  );
endmodule

// File: rtl/mxd_stream_dcs_chk.sv
module mxd_stream_dcs_chk #(
  parameter int unsigned CHANNELS = 8,
  parameter int unsigned SAMPLE_W = 10,
  localparam int unsigned CH_W   = mxd_pkg::mxd_idx_w(CHANNELS),
  localparam int unsigned DIFF_W = SAMPLE_W + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_frame,
  input logic [CH_W-1:0]     out_chan,
  input logic                out_valid,
  input logic [DIFF_W-1:0]   out_diff
);
  localparam int MAG = (1 << SAMPLE_W) - 1;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_chan == '0 && out_diff == '0)); // R1

  AST_OUT_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8

  AST_FRAME_SLOT0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_frame) |=> (out_chan == '0)); // R3

  AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_diff) <= MAG && $signed(out_diff) >= -MAG)); // R7

  if (CHANNELS == (1 << CH_W)) begin : g_pow2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_frame && $past(in_valid) && !$past(rst))
      |=> (out_chan == CH_W'($past(out_chan) + 1'b1))); // R2
  end
endmodule

bind mxd_stream_dcs mxd_stream_dcs_chk #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_frame  (in_frame),
  .out_chan  (out_chan),
  .out_valid (out_valid),
  .out_diff  (out_diff)
);

// File: tb/tb_mxd_stream_dcs.sv
module tb_mxd_stream_dcs;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_frame;
  logic [9:0]  in_sample;
  logic        out_valid;
  logic [2:0]  out_chan;
  logic [10:0] out_diff;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // model state from the requirements
  int  m_slot;
  int  m_hist [8];
  bit  m_seen [8];

  always #10 clk = ~clk;

  mxd_stream_dcs dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame(in_frame),
    .in_sample(in_sample), .out_valid(out_valid), .out_chan(out_chan),
    .out_diff(out_diff)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_frame = 0; in_sample = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_slot = 0;
    for (int i = 0; i < 8; i++) begin m_seen[i] = 0; m_hist[i] = 0; end
  endtask

  // one word, then check at the next falling edge; leaves in_valid high
  task automatic send(input bit fr, input int smp, input string tag);
    int ch; bit ev; int ed;
    ch = fr ? 0 : m_slot;
    ev = m_seen[ch];
    ed = smp - m_hist[ch];
    in_valid = 1; in_frame = fr; in_sample = smp[9:0];
    @(posedge clk); @(negedge clk);
    m_hist[ch] = smp; m_seen[ch] = 1; m_slot = (ch + 1) % 8;
    chk(out_valid == ev, {tag, " valid"}, int'(out_valid), int'(ev));
    chk(int'(out_chan) == ch, {tag, " chan"}, int'(out_chan), ch);
    if (ev) chk(int'($signed(out_diff)) == ed, {tag, " diff"}, int'($signed(out_diff)), ed);
  endtask

  task automatic idle(input int n, input bit fr);
    for (int i = 0; i < n; i++) begin
      in_valid = 0; in_frame = fr;
      @(posedge clk); @(negedge clk);
      chk(out_valid == 0, "R8 idle valid", int'(out_valid), 0);
    end
    in_frame = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == 0, "R1 valid", int'(out_valid), 0);
    chk(out_chan == 0, "R1 chan", int'(out_chan), 0);
    chk(out_diff == 0, "R1 diff", int'(out_diff), 0);
  endtask

  task automatic t_first_pass();
    send(1, 100, "R5");
    for (int i = 1; i < 8; i++) send(0, 100 + 10 * i, "R5");
    idle(1, 0);
  endtask

  task automatic t_second_pass();
    for (int i = 0; i < 8; i++) send(0, 300 - 25 * i, "R6");
    send(0, 17, "R2 wrap");
    idle(1, 0);
  endtask

  task automatic t_frame_mid();
    send(0, 400, "R2");
    send(0, 401, "R2");
    send(1, 55, "R3 frame");
    send(0, 66, "R3 after");
    idle(1, 0);
  endtask

  task automatic t_frame_idle();
    idle(3, 1);
    send(0, 222, "R4");
    send(0, 223, "R4");
    idle(1, 0);
  endtask

  task automatic t_extremes();
    send(1, 0, "R7 lo");
    for (int i = 1; i < 8; i++) send(0, 512, "R7 fill");
    send(1, 1023, "R7 up");
    for (int i = 1; i < 8; i++) send(0, 512, "R7 fill");
    send(1, 0, "R7 down");
    chk(out_diff == 11'h401, "R7 code", int'(out_diff), 'h401);
    idle(1, 0);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 10; i++) begin
      send(i == 0, 600 + 37 * i, "R8 gap");
      idle(2, 0);
    end
  endtask

  task automatic t_reset_again();
    do_reset();
    for (int i = 0; i < 8; i++) send(i == 0, 900 - i, "R9");
    idle(1, 0);
  endtask

  initial begin
    rst = 1; in_valid = 0; in_frame = 0; in_sample = '0;
    t_reset_state();
    t_first_pass();
    t_second_pass();
    t_frame_mid();
    t_frame_idle();
    t_extremes();
    t_gaps();
    t_reset_again();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule